// File: doc/BRIEF.md
# Word-Boundary Detecting Deserializer

This block receives a two-wire serial stream made of a data line and a serial clock. A fast local clock oversamples both wires. Each frame carries a 24-bit payload bit by bit, with one bit per serial clock pulse. The frame ends with two trailer bits. During the trailer the serial clock stays high for three bit periods instead of pulsing. The data line flips to the inverse of the last payload bit and then back to it. A data edge while the serial clock is high therefore only occurs at a frame end. The block uses that edge to find frame alignment.

Each payload bit is captured on a rising edge of the synchronised serial clock. The trailer bits are used only to find the frame end and never reach the output. When a frame end arrives exactly one payload width after the previous one, the collected word is handed to the parallel port with a one-cycle strobe, provided the link is locked. Lock is gained after a set number of correctly spaced frame ends in a row. It is dropped, and the bit counter realigns, whenever a frame end arrives at any other spacing. A parallel clock output is held low for a short time after reset and then follows the serial clock level.

Top module: `wbd_deser`

## Requirements
- R1: While reset is asserted, word_vld_o, lock_o and par_clk_o are 0 and word_o is all zeros.
- R2: After reset is released, par_clk_o stays 0 for PCLK_HOLD (default 4) rising edges of clk. From then on it equals the level ser_clk_i had three rising edges earlier (SYNC_STAGES+1 edges).
- R3: A payload bit is the level of ser_dat_i at a rising edge of ser_clk_i. The first bit of a frame lands in word_o bit 0 and the 24th lands in bit 23.
- R4: A frame end is a change of ser_dat_i while ser_clk_i is high. Only the first change within one high interval counts; later changes in the same interval are ignored.
- R5: A frame end is correctly spaced when exactly DATA_W (default 24) payload bits were captured since the previous frame end. The two trailer bits are never part of word_o.
- R6: lock_o rises at the LOCK_CNT-th (default 2) consecutive correctly spaced frame end. word_vld_o pulses only while lock_o is 1, and the pulse occurs at every correctly spaced frame end from that one on.
- R7: The first frame end after reset, and any frame end that is not correctly spaced, clears lock_o, discards the partial word, restarts the bit count and produces no strobe.
- R8: word_vld_o lasts one clk cycle. It rises on the third rising edge of clk after the data edge that marks the frame end.
- R9: word_o changes only in the cycle in which word_vld_o is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock from the serializer |
| ser_dat_i | input | 1 | Serial data from the serializer |
| word_o | output | DATA_W | Last captured payload word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| par_clk_o | output | 1 | Recovered parallel clock level |
| lock_o | output | 1 | Frame alignment established |

## Verification
The assertions assume the serial wires are slow next to clk:
- Each low and high phase of the serial clock lasts at least two clk cycles.
- Payload data changes only together with, or during, a low phase.
- Both trailer data edges fall at least one clk cycle inside the high phase.

The stimulus drives every wire at the falling edge of clk with four-cycle phases. Trailer edges come four cycles into the stretched high interval. Short and long frames are also sent, so realignment and relocking are exercised under those same timing assumptions.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
   typedef enum logic [1:0] {
      BND_NONE = 2'd0,
      BND_GOOD = 2'd1,
      BND_BAD  = 2'd2
   } bnd_kind_e;
endpackage

// File: rtl/wbd_sync.sv
module wbd_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st_q;

   initial begin
      assert (STAGES >= 2) else $fatal(1, "wbd_sync: STAGES must be at least 2");
      assert (W >= 1)      else $fatal(1, "wbd_sync: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {STAGES{RST_VAL}};
      else        st_q <= {st_q[STAGES-2:0], d};
   end

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/wbd_edge.sv
module wbd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic sdat_s,
   output logic bit_stb,
   output logic bit_val,
   output logic bnd_stb
);
   logic clk_p_q;
   logic dat_p_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_p_q <= 1'b1;
         dat_p_q <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         clk_p_q <= sclk_s;
         dat_p_q <= sdat_s;
         seen_q  <= sclk_s & (seen_q | bnd_stb);
      end
   end

   // payload bit on serial clock rise; frame end on data edge inside a high interval
   assign bit_stb = sclk_s & ~clk_p_q;
   assign bit_val = sdat_s;
   assign bnd_stb = sclk_s & clk_p_q & (sdat_s ^ dat_p_q) & ~seen_q;

   a_r4_one_bnd_per_high: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_stb |=> !bnd_stb);
endmodule

// File: rtl/wbd_frame.sv
module wbd_frame
   import wbd_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int LOCK_CNT  = 2,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              bnd_stb,
   output logic [DATA_W-1:0] word_o,
   output logic              vld_o,
   output logic              lock_o
);
   localparam int CNT_W  = $clog2(DATA_W + 2);
   localparam int GOOD_W = $clog2(LOCK_CNT + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(DATA_W + 1);
   localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CNT);

   logic [DATA_W-1:0] sr_q, sr_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic [GOOD_W-1:0] good_q, good_nxt;
   logic              ref_q;
   bnd_kind_e         kind;

   initial begin
      assert (DATA_W >= 2)   else $fatal(1, "wbd_frame: DATA_W must be at least 2");
      assert (LOCK_CNT >= 1) else $fatal(1, "wbd_frame: LOCK_CNT must be at least 1");
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         assign sr_nxt = {bit_val, sr_q[DATA_W-1:1]};
      end else begin : g_msb
         assign sr_nxt = {sr_q[DATA_W-2:0], bit_val};
      end
   endgenerate

   always_comb begin
      if (!bnd_stb)                        kind = BND_NONE;
      else if (ref_q && cnt_q == CNT_FULL) kind = BND_GOOD;
      else                                 kind = BND_BAD;
      good_nxt = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         good_q <= '0;
         ref_q  <= 1'b0;
         word_o <= '0;
         vld_o  <= 1'b0;
         lock_o <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (bit_stb) begin
            sr_q  <= sr_nxt;
            cnt_q <= (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
         end
         case (kind)
            BND_GOOD: begin
               cnt_q  <= '0;
               good_q <= good_nxt;
               if (good_nxt == GOOD_MAX) begin
                  lock_o <= 1'b1;
                  vld_o  <= 1'b1;
                  word_o <= sr_q;
               end
            end
            BND_BAD: begin
               cnt_q  <= '0;
               good_q <= '0;
               lock_o <= 1'b0;
               ref_q  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   a_r8_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);
   a_r6_vld_locked: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> lock_o);
   a_r6_lock_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> vld_o);
   a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_o) |-> vld_o);
endmodule

// File: rtl/wbd_deser.sv
module wbd_deser #(
   parameter int DATA_W      = 24,
   parameter int LOCK_CNT    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int PCLK_HOLD   = 4,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   output logic [DATA_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              par_clk_o,
   output logic              lock_o
);
   localparam int HOLD_W = $clog2(PCLK_HOLD + 1);

   logic              sclk_s, sdat_s;
   logic              bit_stb, bit_val, bnd_stb;
   logic [HOLD_W-1:0] hold_q;

   initial begin
      assert (PCLK_HOLD >= 1) else $fatal(1, "wbd_deser: PCLK_HOLD must be at least 1");
   end

   wbd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk_i, ser_dat_i}),
      .q     ({sclk_s, sdat_s})
   );

   wbd_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .sdat_s  (sdat_s),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .bnd_stb (bnd_stb)
   );

   wbd_frame #(.DATA_W(DATA_W), .LOCK_CNT(LOCK_CNT), .LSB_FIRST(LSB_FIRST)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .bnd_stb (bnd_stb),
      .word_o  (word_o),
      .vld_o   (word_vld_o),
      .lock_o  (lock_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= HOLD_W'(PCLK_HOLD);
         par_clk_o <= 1'b0;
      end else begin
         if (hold_q != '0) hold_q <= hold_q - 1'b1;
         par_clk_o <= (hold_q == '0) ? sclk_s : 1'b0;
      end
   end

   a_r2_pclk_low_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q != '0) |=> !par_clk_o);
endmodule

// File: tb/sim_wbd_deser.sv
module sim_wbd_deser;
   localparam int W = 24;
   localparam int HOLD = 4;

   typedef struct packed {
      logic         v;
      logic [W-1:0] w;
      logic         l;
      logic         p;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b1;
   logic         sdat = 1'b0;
   logic [W-1:0] word;
   logic         vld, pclk, lock;

   int  checks = 0;
   int  errors = 0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;

   exp_t eq[$];
   logic mbits[$];
   logic mc_p = 1'b1, md_p = 1'b0, mseen = 1'b0, mref = 1'b0, mlock = 1'b0;
   logic [W-1:0] mword = '0;
   int   mgood = 0;

   always #5 clk = ~clk;

   wbd_deser u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk_i  (sclk),
      .ser_dat_i  (sdat),
      .word_o     (word),
      .word_vld_o (vld),
      .par_clk_o  (pclk),
      .lock_o     (lock)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, stepped once per clk on the levels driven before the edge
   always @(posedge clk) begin
      #3;
      if (mon_on) begin
         exp_t e;
         logic v;
         v = 1'b0;
         if (sclk && !mc_p) mbits.push_back(sdat);
         if (sclk && mc_p && (sdat != md_p) && !mseen) begin
            mseen = 1'b1;
            if (mref && mbits.size() == W) begin
               if (mgood < 2) mgood++;
               if (mgood >= 2) begin
                  mlock = 1'b1;
                  v = 1'b1;
                  for (int i = 0; i < W; i++) mword[i] = mbits[i];
               end
            end else begin
               mgood = 0;
               mlock = 1'b0;
            end
            mref = 1'b1;
            mbits.delete();
         end
         if (!sclk) mseen = 1'b0;
         mc_p = sclk;
         md_p = sdat;
         e.v = v; e.w = mword; e.l = mlock; e.p = sclk;
         eq.push_back(e);
         if (eq.size() > 2) begin
            e = eq.pop_front();
            chk(vld == e.v,  "R4/R6/R8 word_vld_o", W'(vld), W'(e.v));
            chk(word == e.w, "R3/R5/R9 word_o",     word,    e.w);
            chk(lock == e.l, "R6/R7 lock_o",        W'(lock), W'(e.l));
            chk(pclk == e.p, "R2 par_clk_o",        W'(pclk), W'(e.p));
         end
      end
   end

   task automatic drive(input logic c, input logic d, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sclk = c;
         sdat = d;
      end
   endtask

   task automatic send_frame(input logic [31:0] w, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         drive(1'b0, w[i], 4);
         drive(1'b1, w[i], 4);
      end
      drive(1'b1, ~w[nbits-1], 4);
      drive(1'b1, w[nbits-1], 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(vld == 1'b0,  "R1 word_vld_o in reset", W'(vld),  '0);
      chk(lock == 1'b0, "R1 lock_o in reset",     W'(lock), '0);
      chk(pclk == 1'b0, "R1 par_clk_o in reset",  W'(pclk), '0);
      chk(word == '0,   "R1 word_o in reset",     word,     '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (HOLD) @(posedge clk);
      #3;
      chk(pclk == 1'b0, "R2 par_clk_o held low", W'(pclk), '0);
      @(posedge clk);
      #3;
      chk(pclk == 1'b1, "R2 par_clk_o released", W'(pclk), W'(1));
      mon_on = 1'b1;

      send_frame(32'h005A3C96, W);    // first frame end: alignment only (R7)
      send_frame(32'h00000000, W);    // first good spacing
      chk(lock == 1'b0, "R6 not yet locked", W'(lock), '0);
      send_frame(32'h00FFFFFF, W);    // lock reached, emitted
      send_frame(32'h00AAAAAA, W);
      send_frame(32'h00123456, W);
      repeat (6) @(negedge clk);
      chk(lock == 1'b1, "R6 locked after good frames", W'(lock), W'(1));
      chk(word == 24'h123456, "R3 LSB-first capture", word, 24'h123456);
      send_frame(32'h000F0F0F, 20);   // short frame
      repeat (6) @(negedge clk);
      chk(lock == 1'b0, "R7 lock cleared on short frame", W'(lock), '0);
      chk(word == 24'h123456, "R9 word held after short frame", word, 24'h123456);
      send_frame(32'h00C0FFEE, W);
      send_frame(32'h00654321, W);
      send_frame(32'h00800001, W);
      send_frame(32'h07ABCDEF, 27);   // long frame
      repeat (6) @(negedge clk);
      chk(lock == 1'b0, "R7 lock cleared on long frame", W'(lock), '0);
      for (int k = 0; k < 6; k++) send_frame({8'h00, 24'($urandom())}, W);
      drive(1'b1, sdat, 20);
      chk(lock == 1'b1, "R6 relocked", W'(lock), W'(1));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule